// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the running count that a PWM module's compare and action stages work from. The fast system clock passes through two prescalers in a row: a power-of-two stage and an even-ratio stage. Their combined output is a one-clock tick enable, so every flop in the block stays on the single input clock. On each tick a 16-bit counter moves up, moves down, moves up and then down, or stays where it is, relative to a programmed period. The block emits one-clock strobes when the count reaches zero and when it reaches the period. Downstream logic uses these strobes to set and clear its outputs.

Software programs the block through a small 16-bit word register port. Period writes go either into a shadow copy, which is promoted to the active period at the next zero reload, or straight into the active period. A debug halt input can stop the count at once or at the end of the current cycle. The block can also be set to ignore that input.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the control register reads 0x0003 (hold mode, shadow loading, both prescale codes 0, stop-now halt policy). Period and count read 0, the direction status bit reads 1, and neither strobe is high.
- R2: Counting mode 0 counts up, one step per tick, from 0 to the active period P and then wraps to 0. Zero strobes are spaced (P+1)*D clocks apart. The period strobe appears with the count equal to P.
- R3: Counting mode 1 counts down one per tick and reloads P after 0. Zero strobes are spaced (P+1)*D clocks apart, and the direction bit reads 0.
- R4: Counting mode 2 rises to P and then falls to 0, giving zero strobes 2*P*D clocks apart. The direction bit reads 0 while the period strobe is high and 1 while the zero strobe is high.
- R5: Counting mode 3 holds the count, and no strobe is raised.
- R6: The tick divide D is 2^A * E. A is control bits 12:10. E is control bits 9:7 times two, with code 0 giving E = 1. The counting mode is control bits 1:0.
- R7: With control bit 3 at 0, a period write lands in the shadow only. The active period takes the shadow value at the next step that brings the count to 0.
- R8: With control bit 3 at 1, a period write takes effect on the active period in the clock after the write.
- R9: Control bits 15:14 set the halt policy for the suspend input. 0 freezes the count at once. 1 lets the count run until it reaches 0 and holds it there. 2 and 3 ignore suspend.
- R10: A write to byte offset 0x08 loads the count directly, and that offset reads back the live count.
- R11: The control register is at offset 0x00 and reads back only bits 15:14, 12:7, 3 and 1:0 (mask 0xDF8B). Status is at 0x02 with the direction in bit 0 (1 = up). The period is at 0x0A. Any other offset reads 0.
- R12: Each strobe is high for one clock per counter step and is registered with the count. The zero strobe is high only while the count output is 0. With D > 1 the strobe falls in the clock after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data (combinational) |
| suspend_in | input | 1 | Debug halt request |
| cnt_o | output | 16 | Current count |
| dir_up_o | output | 1 | Counting direction, 1 = up |
| evt_zero_o | output | 1 | Zero-reached strobe |
| evt_prd_o | output | 1 | Period-reached strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 6-bit byte offset. With these values the counter can be placed anywhere in its range by a single register write, and the combined prescale ratio reaches its full 128 x 14 span. Random configurations keep the period small (1 to 12) and the prescale codes low, so each measured strobe spacing stays within a few hundred clocks. Directed cases cover shadow and immediate period loading, all three halt policies and hold mode.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    localparam int REG_W       = 16;
    localparam int POW_CODE_W  = 3;
    localparam int EVEN_CODE_W = 3;
    // widest stage-one limit is 2^7 - 1, widest stage-two limit is 13
    localparam int POW_CNT_W   = (2 ** POW_CODE_W) - 1;
    localparam int EVEN_CNT_W  = $clog2(2 * ((2 ** EVEN_CODE_W) - 1) + 1);

    // control field positions
    localparam int F_SUSP_LO = 14;
    localparam int F_POW_LO  = 10;
    localparam int F_EVEN_LO = 7;
    localparam int F_IMM     = 3;
    localparam int F_MODE_LO = 0;

    localparam logic [REG_W-1:0] CTRL_RMASK = 16'hDF8B;

    // byte offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h02;
    localparam int OFS_CNT  = 'h08;
    localparam int OFS_PRD  = 'h0A;

    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_HOLD = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        HALT_NOW   = 2'd0,
        HALT_CYCLE = 2'd1,
        HALT_NONE  = 2'd2,
        HALT_NONE2 = 2'd3
    } halt_pol_e;

    typedef struct packed {
        halt_pol_e              halt;
        logic [POW_CODE_W-1:0]  pow_code;
        logic [EVEN_CODE_W-1:0] even_code;
        logic                   prd_imm;
        cnt_mode_e              mode;
    } tb_cfg_t;

    localparam tb_cfg_t CFG_RESET = '{halt: HALT_NOW, pow_code: '0,
                                      even_code: '0, prd_imm: 1'b0,
                                      mode: MODE_HOLD};

    function automatic logic [POW_CNT_W-1:0] pow_limit(input logic [POW_CODE_W-1:0] c);
        logic [POW_CNT_W:0] full;
        full = ((POW_CNT_W+1)'(1) << c) - (POW_CNT_W+1)'(1);
        return full[POW_CNT_W-1:0];
    endfunction

    function automatic logic [EVEN_CNT_W-1:0] even_limit(input logic [EVEN_CODE_W-1:0] c);
        if (c == '0) return '0;
        return EVEN_CNT_W'({c, 1'b0}) - EVEN_CNT_W'(1);
    endfunction

    function automatic tb_cfg_t unpack_ctrl(input logic [REG_W-1:0] w);
        tb_cfg_t c;
        c.halt      = halt_pol_e'(w[F_SUSP_LO +: 2]);
        c.pow_code  = w[F_POW_LO +: POW_CODE_W];
        c.even_code = w[F_EVEN_LO +: EVEN_CODE_W];
        c.prd_imm   = w[F_IMM];
        c.mode      = cnt_mode_e'(w[F_MODE_LO +: 2]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input tb_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[F_SUSP_LO +: 2]           = c.halt;
        w[F_POW_LO +: POW_CODE_W]   = c.pow_code;
        w[F_EVEN_LO +: EVEN_CODE_W] = c.even_code;
        w[F_IMM]                    = c.prd_imm;
        w[F_MODE_LO +: 2]           = c.mode;
        return w;
    endfunction

endpackage

// File: rtl/pwm_tbase_divstage.sv
module pwm_tbase_divstage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] lim,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    // wrap on >= so that a smaller limit written mid-count recovers at once
    assign wrap = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            if (wrap) cnt_q <= '0;
            else      cnt_q <= cnt_q + W'(1);
        end
    end

    // R6
    stage_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wrap) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_tbase_presc.sv
module pwm_tbase_presc
    import pwm_tbase_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [POW_CODE_W-1:0]  pow_code,
    input  logic [EVEN_CODE_W-1:0] even_code,
    output logic                   tick
);
    localparam int NSTAGE = 2;

    logic [NSTAGE-1:0] st_en;
    logic [NSTAGE-1:0] st_wrap;

    assign st_en[0] = 1'b1;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s == 0) begin : g_pow
            pwm_tbase_divstage #(.W(POW_CNT_W)) u_div (
                .clk (clk),
                .rst (rst),
                .en  (st_en[s]),
                .lim (pow_limit(pow_code)),
                .wrap(st_wrap[s])
            );
        end else begin : g_even
            assign st_en[s] = st_en[s-1] & st_wrap[s-1];
            pwm_tbase_divstage #(.W(EVEN_CNT_W)) u_div (
                .clk (clk),
                .rst (rst),
                .en  (st_en[s]),
                .lim (even_limit(even_code)),
                .wrap(st_wrap[s])
            );
        end
    end

    assign tick = st_en[NSTAGE-1] & st_wrap[NSTAGE-1];

endmodule

// File: rtl/pwm_tbase_count.sv
module pwm_tbase_count
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  halt_pol_e        halt,
    input  logic             suspend_in,
    input  logic [CNT_W-1:0] prd,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             evt_zero,
    output logic             evt_prd,
    output logic             reload
);
    logic [CNT_W-1:0] cnt_q, nxt;
    logic             dir_q, ndir;
    logic             evt_zero_q, evt_prd_q;
    logic             halted, step;

    always_comb begin
        halted = 1'b0;
        if (suspend_in) begin
            unique case (halt)
                HALT_NOW:   halted = 1'b1;
                HALT_CYCLE: halted = (cnt_q == '0);
                default:    halted = 1'b0;
            endcase
        end
    end

    assign step = tick && (mode != MODE_HOLD) && !halted && !cnt_wr;

    always_comb begin
        nxt  = cnt_q;
        ndir = dir_q;
        unique case (mode)
            MODE_UP: begin
                nxt  = (cnt_q >= prd) ? '0 : cnt_q + CNT_W'(1);
                ndir = 1'b1;
            end
            MODE_DOWN: begin
                nxt  = (cnt_q == '0) ? prd : cnt_q - CNT_W'(1);
                ndir = 1'b0;
            end
            MODE_UPDN: begin
                if (dir_q)
                    nxt = (cnt_q >= prd) ? ((cnt_q == '0) ? '0 : cnt_q - CNT_W'(1))
                                         : cnt_q + CNT_W'(1);
                else
                    nxt = (cnt_q == '0) ? ((prd == '0) ? '0 : CNT_W'(1))
                                        : cnt_q - CNT_W'(1);
                if (nxt == '0)      ndir = 1'b1;
                else if (nxt >= prd) ndir = 1'b0;
                else                 ndir = dir_q;
            end
            default: begin
                nxt  = cnt_q;
                ndir = dir_q;
            end
        endcase
    end

    assign reload = step && (nxt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            dir_q      <= 1'b1;
            evt_zero_q <= 1'b0;
            evt_prd_q  <= 1'b0;
        end else begin
            evt_zero_q <= reload;
            evt_prd_q  <= step && (nxt == prd);
            if (cnt_wr) begin
                cnt_q <= cnt_wdata;
            end else if (step) begin
                cnt_q <= nxt;
                dir_q <= ndir;
            end
        end
    end

    assign cnt      = cnt_q;
    assign dir_up   = dir_q;
    assign evt_zero = evt_zero_q;
    assign evt_prd  = evt_prd_q;

    // R5
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD && !cnt_wr) |=> $stable(cnt_q));

    // R6
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt_q));

    // R9
    halt_now_chk: assert property (@(posedge clk) disable iff (rst)
        (suspend_in && halt == HALT_NOW && !cnt_wr) |=> $stable(cnt_q));

    // R12
    zero_evt_chk: assert property (@(posedge clk) disable iff (rst)
        evt_zero_q |-> (cnt_q == '0));

    // R4
    updn_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_prd_q && $past(mode) == MODE_UPDN && $past(prd) != '0) |-> !dir_q);

endmodule

// File: rtl/pwm_tbase_regs.sv
module pwm_tbase_regs
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_up,
    input  logic              reload,
    output tb_cfg_t           cfg,
    output logic [CNT_W-1:0]  prd_act,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic [REG_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_PRD  = ADDR_W'(OFS_PRD);

    tb_cfg_t          ctrl_q;
    logic [CNT_W-1:0] prd_sh_q, prd_act_q;
    logic             ctrl_wr, prd_wr;

    assign ctrl_wr   = wr_en && (addr == A_CTRL);
    assign prd_wr    = wr_en && (addr == A_PRD);
    assign cnt_wr    = wr_en && (addr == A_CNT);
    assign cnt_wdata = CNT_W'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CFG_RESET;
            prd_sh_q  <= '0;
            prd_act_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= unpack_ctrl(wdata);
            if (prd_wr) begin
                prd_sh_q <= CNT_W'(wdata);
                if (ctrl_q.prd_imm) prd_act_q <= CNT_W'(wdata);
            end
            if (reload && !(prd_wr && ctrl_q.prd_imm)) prd_act_q <= prd_sh_q;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = pack_ctrl(ctrl_q) & CTRL_RMASK;
            A_STAT:  rdata = REG_W'(dir_up);
            A_CNT:   rdata = REG_W'(cnt);
            A_PRD:   rdata = REG_W'(prd_sh_q);
            default: rdata = '0;
        endcase
    end

    assign cfg     = ctrl_q;
    assign prd_act = prd_act_q;

    // R7 R8
    prd_update_chk: assert property (@(posedge clk) disable iff (rst)
        (prd_act_q != $past(prd_act_q)) |->
            ($past(reload) || ($past(prd_wr) && $past(ctrl_q.prd_imm))));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              suspend_in,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_up_o,
    output logic              evt_zero_o,
    output logic              evt_prd_o
);
    tb_cfg_t          cfg;
    logic [CNT_W-1:0] prd_act, cnt, cnt_wdata;
    logic             cnt_wr, reload, tick, dir_up;

    pwm_tbase_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt      (cnt),
        .dir_up   (dir_up),
        .reload   (reload),
        .cfg      (cfg),
        .prd_act  (prd_act),
        .cnt_wr   (cnt_wr),
        .cnt_wdata(cnt_wdata),
        .rdata    (rdata)
    );

    pwm_tbase_presc u_presc (
        .clk      (clk),
        .rst      (rst),
        .pow_code (cfg.pow_code),
        .even_code(cfg.even_code),
        .tick     (tick)
    );

    pwm_tbase_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (cfg.mode),
        .halt      (cfg.halt),
        .suspend_in(suspend_in),
        .prd       (prd_act),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cnt       (cnt),
        .dir_up    (dir_up),
        .evt_zero  (evt_zero_o),
        .evt_prd   (evt_prd_o),
        .reload    (reload)
    );

    assign cnt_o    = cnt;
    assign dir_up_o = dir_up;

endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        suspend_in = 1'b0;
    logic [15:0] cnt_o;
    logic        dir_up_o, evt_zero_o, evt_prd_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .suspend_in(suspend_in), .cnt_o(cnt_o),
        .dir_up_o(dir_up_o), .evt_zero_o(evt_zero_o), .evt_prd_o(evt_prd_o)
    );

    function automatic int exp_div(input int ck, input int hs);
        return (1 << ck) * ((hs == 0) ? 1 : 2 * hs);
    endfunction

    function automatic int exp_gap(input int mode, input int prd, input int dv);
        if (mode == 2) return 2 * prd * dv;
        return (prd + 1) * dv;
    endfunction

    function automatic logic [15:0] ctrl_word(input int halt, input int ck,
                                              input int hs, input int imm,
                                              input int mode);
        return 16'((halt << 14) | (ck << 10) | (hs << 7) | (imm << 3) | mode);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'(a); wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = 6'(a);
        #1;
        d = int'(rdata);
    endtask

    // sel 0: zero strobe, sel 1: period strobe; n = -1 on timeout
    task automatic wait_evt(input int sel, input int maxc, output int n);
        bit hit;
        n = 0;
        hit = 1'b0;
        while (!hit && n < maxc) begin
            @(negedge clk);
            n++;
            hit = (sel == 0) ? evt_zero_o : evt_prd_o;
        end
        if (!hit) n = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v, n, c0, c1, evs;
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd('h00, v); check(v == 'h0003, "R1 ctrl", v, 'h0003);
        rd('h0A, v); check(v == 0, "R1 period", v, 0);
        rd('h08, v); check(v == 0, "R1 count", v, 0);
        rd('h02, v); check(v == 1, "R1 dir", v, 1);
        check(!evt_zero_o && !evt_prd_o, "R1 strobes", int'(evt_zero_o), 0);

        // R11 register map and mask
        wr('h00, 'hFFFF);
        rd('h00, v); check(v == 'hDF8B, "R11 ctrl mask", v, 'hDF8B);
        rd('h04, v); check(v == 0, "R11 unmapped", v, 0);
        wr('h00, 'h0003);

        // R10 count load, R5 hold mode
        wr('h08, 5);
        rd('h08, v); check(v == 5, "R10 count write", v, 5);
        evs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (evt_zero_o || evt_prd_o) evs++;
        end
        rd('h08, v); check(v == 5, "R5 hold count", v, 5);
        check(evs == 0, "R5 hold strobes", evs, 0);

        // R2 up count, divide 1, period 3
        wr('h00, ctrl_word(2, 0, 0, 1, 0));
        wr('h0A, 3);
        wait_evt(1, 50, n);
        check(cnt_o == 3, "R2 period strobe count", int'(cnt_o), 3);
        wait_evt(0, 50, n);
        check(n == 1, "R2 wrap after period", n, 1);
        check(cnt_o == 0, "R12 zero strobe count", int'(cnt_o), 0);
        wait_evt(0, 50, n);
        check(n == 4, "R2 gap", n, 4);

        // R6 directed: pow code 2, even code 3 -> 24
        wr('h00, ctrl_word(2, 2, 3, 1, 0));
        wr('h0A, 2);
        wait_evt(0, 500, n);
        wait_evt(0, 500, n);
        check(n == 72, "R6 prescale gap", n, 72);
        @(negedge clk);
        check(!evt_zero_o, "R12 one-clock strobe", int'(evt_zero_o), 0);

        // R3 down direction, R4 up-down direction at strobes
        wr('h00, ctrl_word(2, 0, 0, 1, 1));
        wr('h0A, 4);
        wait_evt(1, 50, n);
        rd('h02, v); check(v == 0, "R3 dir down", v, 0);
        wait_evt(1, 50, n);
        check(n == 5, "R3 gap", n, 5);
        wr('h00, ctrl_word(2, 0, 0, 1, 2));
        wait_evt(1, 50, n);
        check(dir_up_o == 1'b0, "R4 dir at period", int'(dir_up_o), 0);
        wait_evt(0, 50, n);
        check(n == 4, "R4 half gap", n, 4);
        check(dir_up_o == 1'b1, "R4 dir at zero", int'(dir_up_o), 1);

        // random configurations
        for (int it = 0; it < 14; it++) begin
            int md, pr, ck, hs, dv, g;
            md = int'($urandom_range(0, 2));
            pr = int'($urandom_range(1, 12));
            ck = int'($urandom_range(0, 2));
            hs = int'($urandom_range(0, 3));
            dv = exp_div(ck, hs);
            g  = exp_gap(md, pr, dv);
            wr('h00, ctrl_word(2, ck, hs, 1, md));
            wr('h0A, pr);
            wait_evt(0, 4 * g + 100, n);
            wait_evt(0, 4 * g + 100, n);
            if (md == 0) check(n == g, "R2 random gap", n, g);
            else if (md == 1) check(n == g, "R3 random gap", n, g);
            else check(n == g, "R4 random gap", n, g);
            check(cnt_o == 0, "R12 random zero count", int'(cnt_o), 0);
            if (dv > 1) begin
                @(negedge clk);
                check(!evt_zero_o, "R12 random strobe width", int'(evt_zero_o), 0);
            end
            if (md != 2) begin
                wait_evt(1, 4 * g + 100, n);
                wait_evt(1, 4 * g + 100, n);
                check(n == g, "R6 random period gap", n, g);
            end
        end

        // R7 shadow loading
        wr('h00, ctrl_word(2, 0, 0, 1, 0));
        wr('h0A, 9);
        wr('h00, ctrl_word(2, 0, 0, 0, 0));
        wait_evt(0, 50, n);
        wr('h0A, 3);
        wait_evt(1, 50, n);
        check(cnt_o == 9, "R7 shadow held", int'(cnt_o), 9);
        wait_evt(0, 50, n);
        wait_evt(0, 50, n);
        check(n == 4, "R7 shadow promoted", n, 4);

        // R8 immediate loading
        wr('h00, ctrl_word(2, 0, 0, 1, 0));
        wr('h0A, 20);
        wr('h08, 1);
        wr('h0A, 6);
        wait_evt(1, 50, n);
        check(cnt_o == 6, "R8 immediate period", int'(cnt_o), 6);

        // R9 halt policies
        wr('h00, ctrl_word(0, 0, 0, 1, 0));
        wr('h0A, 9);
        @(negedge clk);
        suspend_in = 1'b1;
        @(negedge clk);
        c0 = int'(cnt_o);
        repeat (20) @(negedge clk);
        c1 = int'(cnt_o);
        check(c0 == c1, "R9 stop now", c1, c0);
        suspend_in = 1'b0;

        wr('h00, ctrl_word(1, 0, 0, 1, 0));
        wr('h08, 3);
        suspend_in = 1'b1;
        repeat (30) @(negedge clk);
        check(cnt_o == 0, "R9 stop at cycle end", int'(cnt_o), 0);
        repeat (10) @(negedge clk);
        check(cnt_o == 0, "R9 stays at zero", int'(cnt_o), 0);

        wr('h00, ctrl_word(2, 0, 0, 1, 0));
        wait_evt(0, 40, n);
        check(n > 0, "R9 free run ignores suspend", n, 10);
        suspend_in = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule